// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block collects eight interrupt request lines and offers the most urgent one to a processor. A rising edge on a request line marks that line as pending. A pending line takes part in arbitration only if its bit in an 8-bit mask register is clear. Line 0 always has the highest priority and line 7 the lowest. The interrupt output is raised only when the winning candidate outranks every line that the processor is already servicing. This allows nesting by priority.

The processor answers with an acknowledge strobe. On that strobe the winning line moves from pending to in-service, and the block returns a vector byte equal to 08H plus the line number. Software talks to the block through a byte-wide port bus. A write to the mask port loads the mask, and a read of the mask port returns it. Writing the end-of-interrupt code to the command port retires the most urgent line in service, so that requests of equal or lower rank can be offered again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask register holds FFH (all lines blocked), nothing is pending or in service, `int_o` is 0 and `rvalid_o` is 0.
- R2: A request is latched as pending on a 0-to-1 transition of its line. A line held high latches only once. A request that arrives while masked stays pending.
- R3: A write to port 21H loads the mask. Bit n governs line n: 0 enables the line and 1 blocks it. A read of port 21H returns the mask on `rdata_o` with `rvalid_o` high in the next cycle.
- R4: Among enabled pending lines, the lowest line number wins.
- R5: An acknowledge while `int_o` is high places 08H plus the winning line number on `rdata_o`, with `rvalid_o` high for one cycle. The same acknowledge moves that line from pending to in-service.
- R6: `int_o` is high only when the winning candidate has a lower line number than every line in service.
- R7: Writing 20H to port 20H clears only the lowest-numbered in-service bit. Any other value written to port 20H has no effect.
- R8: An acknowledge while `int_o` is low returns nothing and changes no state.
- R9: If an acknowledge and an end-of-interrupt write fall in the same cycle, the end-of-interrupt acts on the in-service set as it was before that acknowledge.
- R10: A new rising edge on a line in the same cycle as that line's acknowledge leaves the line pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Request lines, bit n is line n |
| addr_i | input | 8 | Port address |
| wr_i | input | 1 | Port write strobe |
| wdata_i | input | 8 | Port write data |
| rd_i | input | 1 | Port read strobe |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| rdata_o | output | 8 | Vector or mask read data |
| rvalid_o | output | 1 | Qualifies `rdata_o` for one cycle |

## Verification
Two pairs of events can fall in the same cycle. In the first, an acknowledge arrives together with an end-of-interrupt write. The bench drives both strobes on one edge while line 5 is in service and line 2 is waiting. It then raises line 4 and expects `int_o` to stay low. That result holds only if the retirement hit line 5 and left the new line 2 in service. In the second, a line's new rising edge lands in its own acknowledge cycle. The bench judges this by whether the line is offered again after the next end-of-interrupt.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter logic [7:0] VEC_BASE  = 8'h08,
  parameter logic [7:0] CMD_PORT  = 8'h20,
  parameter logic [7:0] MASK_PORT = 8'h21,
  parameter logic [7:0] EOI_CODE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_i,
  input  logic [7:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  input  logic       inta_i,
  output logic       int_o,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  logic [7:0] irq_q, pend, isr, mask, cand;
  logic [2:0] c_idx, s_idx;
  logic       c_hit, s_hit;

  assign cand = pend & ~mask;

  always_comb begin
    c_hit = 1'b0; c_idx = 3'd0;
    s_hit = 1'b0; s_idx = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (cand[i]) begin c_hit = 1'b1; c_idx = 3'(i); end
      if (isr[i])  begin s_hit = 1'b1; s_idx = 3'(i); end
    end
  end

  assign int_o = c_hit && (!s_hit || c_idx < s_idx);

  logic       ack, eoi, mask_wr, mask_rd;
  logic [7:0] ack_set, eoi_clr;

  assign ack     = inta_i && int_o;
  assign eoi     = wr_i && addr_i == CMD_PORT && wdata_i == EOI_CODE;
  assign mask_wr = wr_i && addr_i == MASK_PORT;
  assign mask_rd = rd_i && addr_i == MASK_PORT;
  assign ack_set = ack ? (8'b1 << c_idx) : 8'h00;
  assign eoi_clr = (eoi && s_hit) ? (8'b1 << s_idx) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 8'h00;
      pend     <= 8'h00;
      isr      <= 8'h00;
      mask     <= 8'hFF;
      rdata_o  <= 8'h00;
      rvalid_o <= 1'b0;
    end else begin
      irq_q    <= irq_i;
      pend     <= (pend & ~ack_set) | (irq_i & ~irq_q);
      isr      <= (isr & ~eoi_clr) | ack_set;
      if (mask_wr) mask <= wdata_i;
      rvalid_o <= ack || mask_rd;
      if (ack)          rdata_o <= VEC_BASE + {5'b0, c_idx};
      else if (mask_rd) rdata_o <= mask;
    end
  end

  // R5
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && int_o) |=> rvalid_o && rdata_o >= VEC_BASE && rdata_o < VEC_BASE + 8'd8);

  // R5
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && int_o) |=> isr[$past(c_idx)]);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && !int_o && !(rd_i && addr_i == MASK_PORT)) |=> !rvalid_o);

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (pend & ~mask) != 8'h00);

  // R7
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr != 8'h00) |=> $countones(isr) + 1 == $past($countones(isr)));

  // R7
  other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi && !ack) |=> $countones(isr) <= $past($countones(isr)));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq = 8'h00, addr = 8'h00, wdata = 8'h00;
  logic       wr = 1'b0, rd = 1'b0, inta = 1'b0;
  logic       int_o, rvalid;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .inta_i(inta), .int_o(int_o),
    .rdata_o(rdata), .rvalid_o(rvalid));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as read data appears
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 actual unexpected data %02h expected none", rdata);
      end else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic set_irq(int n, logic v);
    @(negedge clk); irq[n] = v;
    @(negedge clk);
  endtask

  task automatic wr_port(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_mask(string tag, logic [7:0] exp);
    @(negedge clk); addr = 8'h21; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ack(string tag, logic [7:0] exp);
    @(negedge clk); inta = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic ack_none();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 int after reset", {7'b0, int_o}, 8'h00);
    chk("R1 rvalid after reset", {7'b0, rvalid}, 8'h00);
    rd_mask("R1 mask reset value", 8'hFF);

    wr_port(8'h21, 8'hFE);
    rd_mask("R3 mask readback", 8'hFE);
    set_irq(3, 1'b1);
    chk("R3 masked line quiet", {7'b0, int_o}, 8'h00);
    set_irq(0, 1'b1);
    chk("R3 enabled line raises int", {7'b0, int_o}, 8'h01);
    wr_port(8'h21, 8'h00);
    ack("R4 R5 vector line0", 8'h08);
    chk("R6 lower line blocked by isr", {7'b0, int_o}, 8'h00);
    ack_none();
    chk("R8 ack ignored state", {7'b0, int_o}, 8'h00);

    wr_port(8'h20, 8'h33);
    chk("R7 other cmd ignored", {7'b0, int_o}, 8'h00);
    wr_port(8'h20, 8'h20);
    chk("R2 R7 eoi releases masked-pending line3", {7'b0, int_o}, 8'h01);
    ack("R5 vector line3", 8'h0B);
    chk("R2 held line0 no relatch", {7'b0, int_o}, 8'h00);
    set_irq(1, 1'b1);
    chk("R6 higher line nests", {7'b0, int_o}, 8'h01);
    ack("R5 vector line1", 8'h09);
    wr_port(8'h20, 8'h20);
    set_irq(5, 1'b1);
    chk("R7 eoi cleared only line1", {7'b0, int_o}, 8'h00);
    wr_port(8'h20, 8'h20);
    chk("R7 second eoi clears line3", {7'b0, int_o}, 8'h01);

    @(negedge clk); irq = 8'h00;
    ack("R5 vector line5", 8'h0D);
    set_irq(2, 1'b1);
    chk("R6 line2 above line5", {7'b0, int_o}, 8'h01);
    @(negedge clk); inta = 1'b1; addr = 8'h20; wdata = 8'h20; wr = 1'b1;
    exp_q.push_back(8'h0A); tag_q.push_back("R9 vector line2 with eoi");
    @(negedge clk); inta = 1'b0; wr = 1'b0;
    set_irq(4, 1'b1);
    chk("R9 eoi hit old line5, line2 in service", {7'b0, int_o}, 8'h00);
    wr_port(8'h20, 8'h20);
    chk("R9 line4 offered after eoi", {7'b0, int_o}, 8'h01);
    ack("R5 vector line4", 8'h0C);
    wr_port(8'h20, 8'h20);

    set_irq(6, 1'b1);
    set_irq(6, 1'b0);
    @(negedge clk); inta = 1'b1; irq[6] = 1'b1;
    exp_q.push_back(8'h0E); tag_q.push_back("R10 vector line6");
    @(negedge clk); inta = 1'b0;
    chk("R10 equal rank waits", {7'b0, int_o}, 8'h00);
    wr_port(8'h20, 8'h20);
    chk("R10 line6 pending again", {7'b0, int_o}, 8'h01);
    ack("R10 second vector line6", 8'h0E);
    wr_port(8'h20, 8'h20);

    @(negedge clk); irq = 8'h00;
    wr_port(8'h21, 8'h04);
    @(negedge clk); irq[7] = 1'b1; irq[2] = 1'b1;
    @(negedge clk);
    ack("R3 R4 masked line2 skipped", 8'h0F);
    wr_port(8'h20, 8'h20);
    wr_port(8'h21, 8'h00);
    ack("R4 unmasked line2 wins", 8'h0A);
    wr_port(8'h20, 8'h20);
    chk("R5 nothing left", {7'b0, int_o}, 8'h00);

    repeat (3) @(negedge clk);
    chk("R5 all expected data seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule